// File: doc/BRIEF.md
# Tagged Register File with Token Propagation

This block is a small integer register file in which every general register holds one extra token bit beside its data. A set token marks the value as untrusted or as carrying a deferred exception. The block executes one decoded operation per cycle on an execution port. That operation may be an ALU operation, a compare, a check, a token set or clear, a move to the special register, or a token spill. A separate writeback port carries load results, including speculative loads that faulted.

Tokens travel with the data. An ALU result is tainted when any of its sources is tainted, with one exception: XOR or subtract of a register with itself always gives a clean result. A tainted operand changes how the other operations behave. Compares in default mode give up and clear both predicates. A check asks for a jump to a recovery target. A move to the special register is refused and raises a fault. All results come out registered, one clock after the operation is presented. A register write becomes visible to the operation in the next cycle.

Top module: `tagged_regfile`

## Requirements
- R1: ALU opcodes are ADD=1, SUB=2, AND=3, OR=4, XOR=5. Each writes the computed data to the destination register, with token = token(a) OR token(b), and shows the same data and token on res_data/res_tok with res_valid high.
- R2: SUB=2 or XOR=5 with src_a equal to src_b gives a clear token, whatever the source token is.
- R3: A load writeback with ld_fault high writes data zero and sets the token. With ld_fault low, it writes ld_data and clears the token.
- R4: CHK=8 on src_a raises recov_req with recov_target = op_target when the token of src_a is set. With a clear token, recov_req stays low and recov_target reads zero.
- R5: With cmp_aware low, CMPEQ=6 or CMPLTU=7 (unsigned) with any tainted source gives pred_valid high and both pred_t and pred_f low.
- R6: With cmp_aware high, or with both sources clean, the compare gives pred_t = condition and pred_f = its inverse.
- R7: MVSR=11 with a tainted src_a raises fault and leaves sreg_q unchanged. With a clean src_a, it copies the data into sreg_q and does not raise fault.
- R8: TSET=9 and TCLR=10 set or clear only the token of register dst, and leave its data unchanged.
- R9: SPILL=12 copies the token of src_a into bit src_a of tsave_q and leaves the other bits unchanged.
- R10: Register 0 reads as data zero with a clear token. Writes to it from either port, including token writes, have no effect.
- R11: When the execution port and the load port write the same register in the same cycle, the execution port's write is kept and the load is dropped. Loads to other registers in that cycle still take effect.
- R12: Every output reflects the operation presented in the cycle before. A register written in one cycle is read with its new value by the next operation. Outputs with no event in that cycle read zero. After reset all outputs and registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present on the execution port |
| op_code | input | 4 | Operation code |
| op_src_a | input | 4 | First source register index |
| op_src_b | input | 4 | Second source register index |
| op_dst | input | 4 | Destination register index |
| op_target | input | 16 | Recovery target for check operations |
| cmp_aware | input | 1 | Compare mode: 1 computes predicates ignoring tokens |
| ld_valid | input | 1 | Load writeback present |
| ld_dst | input | 4 | Load destination register |
| ld_data | input | 32 | Load data |
| ld_fault | input | 1 | Speculative load faulted |
| res_valid | output | 1 | ALU result valid |
| res_data | output | 32 | ALU result data |
| res_tok | output | 1 | ALU result token |
| pred_valid | output | 1 | Compare result valid |
| pred_t | output | 1 | True predicate |
| pred_f | output | 1 | False predicate |
| recov_req | output | 1 | Branch-to-recovery request |
| recov_target | output | 16 | Recovery target |
| fault | output | 1 | Illegal consumption of a tainted value |
| sreg_q | output | 32 | Special register contents |
| tsave_q | output | 16 | Token-save register |

## Verification
Two functions can meet in the same cycle: an execution-port write and a load writeback. They conflict when both name one destination. The bench provokes this by issuing an ADD and a token set together with a load to the same register. It then reads that register back with OR against register 0 and compares data and token with a model in which the operation wins. The bench also pairs an operation with a load to a different register, to show that both writes land.

// File: rtl/trf_pkg.sv
package trf_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_ADD    = 4'd1,
    OP_SUB    = 4'd2,
    OP_AND    = 4'd3,
    OP_OR     = 4'd4,
    OP_XOR    = 4'd5,
    OP_CMPEQ  = 4'd6,
    OP_CMPLTU = 4'd7,
    OP_CHK    = 4'd8,
    OP_TSET   = 4'd9,
    OP_TCLR   = 4'd10,
    OP_MVSR   = 4'd11,
    OP_SPILL  = 4'd12
  } op_e;

  function automatic logic is_alu(op_e op);
    return op inside {OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR};
  endfunction

  function automatic logic is_cmp(op_e op);
    return op inside {OP_CMPEQ, OP_CMPLTU};
  endfunction
endpackage

// File: rtl/trf_regs.sv
module trf_regs #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0][IW-1:0]  rd_idx,
  output logic [1:0][DW-1:0]  rd_data,
  output logic [1:0]          rd_tok,
  input  logic                wa_en,
  input  logic                wa_tok_only,
  input  logic [IW-1:0]       wa_idx,
  input  logic [DW-1:0]       wa_data,
  input  logic                wa_tok,
  input  logic                wb_en,
  input  logic [IW-1:0]       wb_idx,
  input  logic [DW-1:0]       wb_data,
  input  logic                wb_tok
);
  logic [DW-1:0]   data_q [NREG];
  logic [NREG-1:0] tok_q;

  // Execution port has priority over the load port; index 0 is never written.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) data_q[i] <= '0;
      tok_q <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (wa_en && wa_idx == IW'(i)) begin
          tok_q[i] <= wa_tok;
          if (!wa_tok_only) data_q[i] <= wa_data;
        end else if (wb_en && wb_idx == IW'(i)) begin
          data_q[i] <= wb_data;
          tok_q[i]  <= wb_tok;
        end
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd_data[p] = (rd_idx[p] == '0) ? '0 : data_q[rd_idx[p]];
    assign rd_tok[p]  = (rd_idx[p] == '0) ? 1'b0 : tok_q[rd_idx[p]];
  end
endmodule

// File: rtl/trf_exec.sv
module trf_exec
  import trf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          op_valid,
  input  op_e           op,
  input  logic          same_src,
  input  logic [DW-1:0] a_data,
  input  logic          a_tok,
  input  logic [DW-1:0] b_data,
  input  logic          b_tok,
  input  logic          cmp_aware,
  output logic          wr_en,
  output logic          wr_tok_only,
  output logic [DW-1:0] wr_data,
  output logic          wr_tok,
  output logic          alu_fire,
  output logic          cmp_fire,
  output logic          cmp_t,
  output logic          cmp_f,
  output logic          chk_hit,
  output logic          sr_write,
  output logic          sr_fault,
  output logic          spill_fire
);
  function automatic logic [DW-1:0] alu_value(op_e o, logic [DW-1:0] x, logic [DW-1:0] y);
    case (o)
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_AND:  return x & y;
      OP_OR:   return x | y;
      OP_XOR:  return x ^ y;
      default: return '0;
    endcase
  endfunction

  function automatic logic merged_token(op_e o, logic same, logic tx, logic ty);
    if ((o == OP_SUB || o == OP_XOR) && same) return 1'b0;
    return tx | ty;
  endfunction

  function automatic logic compare_true(op_e o, logic [DW-1:0] x, logic [DW-1:0] y);
    return (o == OP_CMPEQ) ? (x == y) : (x < y);
  endfunction

  logic cond;
  logic blind;

  always_comb begin
    wr_en       = 1'b0;
    wr_tok_only = 1'b0;
    wr_data     = '0;
    wr_tok      = 1'b0;
    alu_fire    = 1'b0;
    cmp_fire    = 1'b0;
    cmp_t       = 1'b0;
    cmp_f       = 1'b0;
    chk_hit     = 1'b0;
    sr_write    = 1'b0;
    sr_fault    = 1'b0;
    spill_fire  = 1'b0;
    cond        = compare_true(op, a_data, b_data);
    blind       = !cmp_aware && (a_tok || b_tok);
    if (op_valid) begin
      if (is_alu(op)) begin
        alu_fire = 1'b1;
        wr_en    = 1'b1;
        wr_data  = alu_value(op, a_data, b_data);
        wr_tok   = merged_token(op, same_src, a_tok, b_tok);
      end else if (is_cmp(op)) begin
        cmp_fire = 1'b1;
        cmp_t    = !blind && cond;
        cmp_f    = !blind && !cond;
      end else begin
        case (op)
          OP_CHK:  chk_hit = a_tok;
          OP_TSET, OP_TCLR: begin
            wr_en       = 1'b1;
            wr_tok_only = 1'b1;
            wr_tok      = (op == OP_TSET);
          end
          OP_MVSR: begin
            sr_fault = a_tok;
            sr_write = !a_tok;
          end
          OP_SPILL: spill_fire = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile
  import trf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int TW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [IW-1:0] op_src_a,
  input  logic [IW-1:0] op_src_b,
  input  logic [IW-1:0] op_dst,
  input  logic [TW-1:0] op_target,
  input  logic          cmp_aware,
  input  logic          ld_valid,
  input  logic [IW-1:0] ld_dst,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_fault,
  output logic          res_valid,
  output logic [DW-1:0] res_data,
  output logic          res_tok,
  output logic          pred_valid,
  output logic          pred_t,
  output logic          pred_f,
  output logic          recov_req,
  output logic [TW-1:0] recov_target,
  output logic          fault,
  output logic [DW-1:0] sreg_q,
  output logic [NREG-1:0] tsave_q
);
  op_e                 op_dec;
  logic [1:0][IW-1:0]  rd_idx;
  logic [1:0][DW-1:0]  rd_data;
  logic [1:0]          rd_tok;
  logic                wr_en, wr_tok_only, wr_tok;
  logic [DW-1:0]       wr_data;
  logic                alu_fire, cmp_fire, cmp_t, cmp_f;
  logic                chk_hit, sr_write, sr_fault, spill_fire;

  assign op_dec = op_e'(op_code);
  assign rd_idx = {op_src_b, op_src_a};

  trf_regs #(.NREG(NREG), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_tok(rd_tok),
    .wa_en(wr_en), .wa_tok_only(wr_tok_only), .wa_idx(op_dst),
    .wa_data(wr_data), .wa_tok(wr_tok),
    .wb_en(ld_valid), .wb_idx(ld_dst),
    .wb_data(ld_fault ? '0 : ld_data), .wb_tok(ld_fault)
  );

  trf_exec #(.DW(DW)) u_exec (
    .op_valid(op_valid), .op(op_dec), .same_src(op_src_a == op_src_b),
    .a_data(rd_data[0]), .a_tok(rd_tok[0]),
    .b_data(rd_data[1]), .b_tok(rd_tok[1]),
    .cmp_aware(cmp_aware),
    .wr_en(wr_en), .wr_tok_only(wr_tok_only), .wr_data(wr_data), .wr_tok(wr_tok),
    .alu_fire(alu_fire), .cmp_fire(cmp_fire), .cmp_t(cmp_t), .cmp_f(cmp_f),
    .chk_hit(chk_hit), .sr_write(sr_write), .sr_fault(sr_fault),
    .spill_fire(spill_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_data     <= '0;
      res_tok      <= 1'b0;
      pred_valid   <= 1'b0;
      pred_t       <= 1'b0;
      pred_f       <= 1'b0;
      recov_req    <= 1'b0;
      recov_target <= '0;
      fault        <= 1'b0;
      sreg_q       <= '0;
      tsave_q      <= '0;
    end else begin
      res_valid    <= alu_fire;
      res_data     <= alu_fire ? wr_data : '0;
      res_tok      <= alu_fire && wr_tok;
      pred_valid   <= cmp_fire;
      pred_t       <= cmp_t;
      pred_f       <= cmp_f;
      recov_req    <= chk_hit;
      recov_target <= chk_hit ? op_target : '0;
      fault        <= sr_fault;
      if (sr_write) sreg_q <= rd_data[0];
      if (spill_fire) tsave_q[op_src_a] <= rd_tok[0];
    end
  end
endmodule

// File: rtl/trf_checker.sv
module trf_checker
  import trf_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  localparam int IW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [3:0]      op_code,
  input logic            cmp_aware,
  input logic [IW-1:0]   src_a,
  input logic [DW-1:0]   a_data,
  input logic            a_tok,
  input logic            res_valid,
  input logic            pred_valid,
  input logic            pred_t,
  input logic            pred_f,
  input logic            recov_req,
  input logic            fault,
  input logic [DW-1:0]   sreg_q,
  input logic [NREG-1:0] tsave_q
);
  p_recov_from_chk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    recov_req |-> $past(op_valid && op_code == OP_CHK && a_tok));

  p_blind_compare_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && !pred_t && !pred_f) |-> !$past(cmp_aware));

  p_aware_compare_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && $past(cmp_aware)) |-> (pred_t != pred_f));

  p_fault_holds_sreg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (sreg_q == $past(sreg_q)));

  p_tsave_single_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tsave_q ^ $past(tsave_q)) <= 1);

  p_reg0_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a == '0) |-> (a_data == '0 && !a_tok));

  p_result_after_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || pred_valid) |-> $past(op_valid));
endmodule

bind tagged_regfile trf_checker #(.NREG(NREG), .DW(DW)) u_trf_checker (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .cmp_aware(cmp_aware), .src_a(op_src_a), .a_data(rd_data[0]), .a_tok(rd_tok[0]),
  .res_valid(res_valid), .pred_valid(pred_valid), .pred_t(pred_t), .pred_f(pred_f),
  .recov_req(recov_req), .fault(fault), .sreg_q(sreg_q), .tsave_q(tsave_q)
);

// File: tb/test_tagged_regfile.sv
module test_tagged_regfile;
  localparam logic [3:0] NOP = 0, ADD = 1, SUB = 2, AND_ = 3, OR_ = 4, XOR_ = 5,
                         CEQ = 6, CLT = 7, CHK = 8, TSET = 9, TCLR = 10,
                         MVSR = 11, SPILL = 12;
  localparam int EW = 103;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, cmp_aware = 0, ld_valid = 0, ld_fault = 0;
  logic [3:0] op_code = 0, op_src_a = 0, op_src_b = 0, op_dst = 0, ld_dst = 0;
  logic [15:0] op_target = 0;
  logic [31:0] ld_data = 0;
  logic res_valid, res_tok, pred_valid, pred_t, pred_f, recov_req, fault;
  logic [31:0] res_data, sreg_q;
  logic [15:0] recov_target, tsave_q;

  always #10 clk = ~clk;

  tagged_regfile i_tagged_regfile (.*);

  int checks = 0, fails = 0;
  logic [EW-1:0] exp_q[$];
  string tag_q[$];

  logic [31:0] mdata [16];
  logic [15:0] mtok = 0, mts = 0;
  logic [31:0] msr = 0;

  function automatic logic [EW-1:0] actual();
    return {res_valid, res_data, res_tok, pred_valid, pred_t, pred_f,
            recov_req, recov_target, fault, sreg_q, tsave_q};
  endfunction

  task automatic judge(input logic [EW-1:0] exp, input string tag);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  // Driver: presents one operation and pushes the expected next-cycle outputs.
  task automatic issue(input logic [3:0] op, input int a, input int b, input int d,
                       input logic [15:0] tg, input logic lv, input int ld,
                       input logic [31:0] ldat, input logic lf, input string tag);
    logic [31:0] ad, bd, rd;
    logic at, bt, rt, rv, pv, pt, pf, rq, fl, c, opw;
    logic [15:0] rtg;
    @(negedge clk);
    op_valid = (op != NOP); op_code = op; op_src_a = a[3:0]; op_src_b = b[3:0];
    op_dst = d[3:0]; op_target = tg; ld_valid = lv; ld_dst = ld[3:0];
    ld_data = ldat; ld_fault = lf;
    ad = (a == 0) ? 0 : mdata[a]; at = (a == 0) ? 0 : mtok[a];
    bd = (b == 0) ? 0 : mdata[b]; bt = (b == 0) ? 0 : mtok[b];
    {rv, rd, rt, pv, pt, pf, rq, rtg, fl} = '0;
    opw = 0;
    if (op >= ADD && op <= XOR_) begin
      rv = 1;
      case (op)
        ADD: rd = ad + bd;
        SUB: rd = ad - bd;
        AND_: rd = ad & bd;
        OR_: rd = ad | bd;
        default: rd = ad ^ bd;
      endcase
      rt = ((op == SUB || op == XOR_) && a == b) ? 1'b0 : (at | bt);
      opw = 1;
    end else if (op == CEQ || op == CLT) begin
      pv = 1;
      c = (op == CEQ) ? (ad == bd) : (ad < bd);
      if (!cmp_aware && (at | bt)) begin pt = 0; pf = 0; end
      else begin pt = c; pf = !c; end
    end else if (op == CHK) begin
      if (at) begin rq = 1; rtg = tg; end
    end else if (op == TSET || op == TCLR) begin
      opw = 1;
    end else if (op == MVSR) begin
      if (at) fl = 1; else msr = ad;
    end else if (op == SPILL) begin
      mts[a] = at;
    end
    if (lv && ld != 0 && !(opw && d == ld)) begin
      mdata[ld] = lf ? 32'h0 : ldat;
      mtok[ld] = lf;
    end
    if (opw && d != 0) begin
      if (op == TSET || op == TCLR) mtok[d] = (op == TSET);
      else begin mdata[d] = rd; mtok[d] = rt; end
    end
    exp_q.push_back({rv, rd, rt, pv, pt, pf, rq, rtg, fl, msr, mts});
    tag_q.push_back(tag);
  endtask

  task automatic op(input logic [3:0] o, input int a, input int b, input int d, input string tag);
    issue(o, a, b, d, 16'h0, 1'b0, 0, 32'h0, 1'b0, tag);
  endtask

  task automatic load(input int ld, input logic [31:0] v, input logic f, input string tag);
    issue(NOP, 0, 0, 0, 16'h0, 1'b1, ld, v, f, tag);
  endtask

  // Monitor: pops one expected item per cycle, away from the clock edge.
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk); #5;
      if (exp_q.size() > 0) judge(exp_q.pop_front(), tag_q.pop_front());
    end
  end

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdata[i] = 0;
    repeat (3) @(posedge clk);
    #5 judge('0, "R12 reset state");
    @(negedge clk) rst_n = 1;
    op(OR_, 5, 5, 0, "R12 idle read after reset");
    load(1, 32'h1234, 0, "R3 clean load r1");
    load(2, 32'h10, 0, "R3 clean load r2");
    op(ADD, 1, 2, 3, "R1 add clean");
    load(4, 32'h5555, 1, "R3 faulting load r4");
    op(OR_, 4, 4, 0, "R3 faulted data zero token set");
    op(ADD, 1, 4, 5, "R1 add with tainted source");
    op(AND_, 1, 2, 6, "R1 and");
    op(SUB, 2, 1, 6, "R1 sub");
    op(XOR_, 3, 5, 7, "R1 xor tainted");
    op(XOR_, 5, 5, 7, "R2 xor self clears token");
    op(SUB, 4, 4, 7, "R2 sub self clears token");
    op(SUB, 1, 4, 8, "R2 sub different sources keeps token");
    op(OR_, 7, 0, 0, "R2 readback r7");
    issue(CHK, 5, 0, 0, 16'hBEEF, 0, 0, 0, 0, "R4 check tainted");
    issue(CHK, 3, 0, 0, 16'hCAFE, 0, 0, 0, 0, "R4 check clean");
    op(CEQ, 1, 1, 0, "R6 compare clean default mode");
    op(CLT, 4, 1, 0, "R5 compare tainted default mode");
    op(CEQ, 5, 1, 0, "R5 compare tainted eq default mode");
    @(negedge clk) cmp_aware = 1;
    op(CLT, 4, 1, 0, "R6 aware compare tainted lt");
    op(CEQ, 5, 2, 0, "R6 aware compare tainted ne");
    @(negedge clk) cmp_aware = 0;
    op(MVSR, 5, 0, 0, "R7 move tainted faults");
    op(MVSR, 3, 0, 0, "R7 move clean writes");
    op(MVSR, 4, 0, 0, "R7 second tainted move keeps sreg");
    op(TCLR, 0, 0, 5, "R8 clear token r5");
    op(OR_, 5, 0, 0, "R8 r5 data kept token clear");
    op(TSET, 0, 0, 3, "R8 set token r3");
    op(OR_, 3, 0, 0, "R8 r3 data kept token set");
    op(SPILL, 3, 0, 0, "R9 spill tainted r3");
    op(SPILL, 1, 0, 0, "R9 spill clean r1");
    op(SPILL, 4, 0, 0, "R9 spill tainted r4");
    load(3, 32'h77, 0, "R3 plain reload r3");
    op(OR_, 3, 0, 0, "R3 reload token clear");
    op(ADD, 1, 2, 0, "R10 write r0 ignored");
    op(TSET, 0, 0, 0, "R10 token set r0 ignored");
    load(0, 32'hFFFF, 1, "R10 load r0 ignored");
    op(OR_, 0, 0, 8, "R10 r0 reads zero clean");
    issue(ADD, 1, 2, 9, 0, 1, 9, 32'hAAAA, 1, "R11 clash alu wins");
    op(OR_, 9, 0, 0, "R11 readback r9");
    issue(TSET, 0, 0, 10, 0, 1, 10, 32'hBBBB, 0, "R11 clash token op wins");
    op(OR_, 10, 0, 0, "R11 readback r10");
    issue(ADD, 1, 1, 11, 0, 1, 12, 32'h42, 0, "R11 different targets both write");
    op(ADD, 11, 12, 13, "R12 back-to-back dependent read");
    op(XOR_, 13, 1, 14, "R12 chained result");
    op(NOP, 0, 0, 0, "R12 idle outputs zero");
    repeat (3) @(posedge clk);
    #6;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule